// File: doc/BRIEF.md
# External Request Dispatch Unit

This block sits on the processor side of a shared system bus. After the outside agent has won the bus, it presents one request at a time: read, write, invalidate, update, snoop, intervention or null. The unit decodes the command and acts on a small model of the caches. Each line holds one secondary-level state, one primary-level valid bit and one data line that stands for both levels. The unit also holds a single interrupt register, which is the only resource an external write can reach. When a request needs a reply, the unit sends it and marks the request complete with a one-cycle `done` pulse.

Read responses to the processor's own reads do not pass through this sequencing. They arrive on their own path without arbitration. When the data identifier of a read response marks the data as bad, the unit raises a bus-error pulse.

Top module: `ext_req_unit`

## Requirements
- R1: `req_ready` is high when idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low during the next cycle. `done` is high for exactly one cycle, after the second edge following acceptance, and `req_ready` returns high in that same cycle.
- R2: `req_cmd` encodes the request kind: 0 null, 1 read, 2 write, 3 invalidate, 4 update, 5 snoop, 6 intervention. The value 7 behaves exactly as null.
- R3: A write with `req_addr`==0 loads `req_wdata[WORD_W-1:0]` into the interrupt register. A write to any other address changes nothing. A read replies with `rep_valid` and puts the interrupt register, zero-extended, on `rep_data` when `req_addr`==0; for other addresses `rep_data` is zero.
- R4: An invalidate sets the line's state to invalid (0) and clears its primary valid bit. It sends no reply.
- R5: An update merges `req_wdata` into the line byte by byte, for each set bit of `req_be` (bit i covers byte i). It sets the state to dirty (3) and the primary valid bit. It sends no reply.
- R6: A snoop replies with the line state in `rep_state` and the primary valid bit in `rep_l1`, with no data. When `req_excl` is 1 the line becomes invalid with its primary bit cleared; otherwise the state is unchanged.
- R7: An intervention replies with the line state and the primary valid bit. When the state is dirty (3), it also sets `rep_has_data` and puts the line on `rep_data`. With `req_excl`=1 the line becomes invalid and its primary bit is cleared. With `req_excl`=0 a valid line becomes shared (1).
- R8: A null request changes no state and sends no reply; it only produces `done`.
- R9: `bus_err` is high in the cycle after an edge where `rd_rsp_valid` and `rd_rsp_err` are both high, and low otherwise. This holds whether or not a request is in flight.
- R10: `rep_valid` is high only together with `done`, and only for read, snoop and intervention. `rep_has_data` is high only with `rep_valid` and a dirty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | External request present |
| req_ready | output | 1 | Unit can accept a request |
| req_cmd | input | 3 | Request kind |
| req_addr | input | IDX_W | Line index, or resource address for read/write |
| req_excl | input | 1 | Snoop/intervention kind: 1 exclusive, 0 shared |
| req_wdata | input | LINE_W | Write or update data |
| req_be | input | LINE_W/8 | Byte enables for update |
| rd_rsp_valid | input | 1 | Read response beat present |
| rd_rsp_err | input | 1 | Data identifier marks the beat erroneous |
| done | output | 1 | One-cycle completion pulse |
| rep_valid | output | 1 | Reply present |
| rep_state | output | 2 | Line state reported |
| rep_l1 | output | 1 | Primary valid bit reported |
| rep_has_data | output | 1 | Reply carries line contents |
| rep_data | output | LINE_W | Reply data |
| bus_err | output | 1 | Bus-error indication |

## Verification
The bench builds the unit with LINES=4, LINE_W=64 and WORD_W=32. With four lines, the top index 3 and index 0 are cheap to exercise. Index 0 is the address that doubles as the interrupt register's resource address. A 64-bit line with eight byte enables allows a partial-update merge that can be told apart from a full one. State transitions are followed through the full chain, from update (dirty) to shared intervention (shared) to exclusive snoop (invalid), with each step observed through later replies.

// File: rtl/ext_req_unit.sv
module ext_req_unit #(
  parameter int LINES  = 8,
  parameter int LINE_W = 64,
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [2:0]                  req_cmd,
  input  logic [$clog2(LINES)-1:0]    req_addr,
  input  logic                        req_excl,
  input  logic [LINE_W-1:0]           req_wdata,
  input  logic [LINE_W/8-1:0]         req_be,
  input  logic                        rd_rsp_valid,
  input  logic                        rd_rsp_err,
  output logic                        done,
  output logic                        rep_valid,
  output logic [1:0]                  rep_state,
  output logic                        rep_l1,
  output logic                        rep_has_data,
  output logic [LINE_W-1:0]           rep_data,
  output logic                        bus_err
);
  localparam int IDX_W = $clog2(LINES);
  localparam int BE_W  = LINE_W / 8;

  localparam logic [2:0] C_READ  = 3'd1;
  localparam logic [2:0] C_WRITE = 3'd2;
  localparam logic [2:0] C_INVAL = 3'd3;
  localparam logic [2:0] C_UPD   = 3'd4;
  localparam logic [2:0] C_SNOOP = 3'd5;
  localparam logic [2:0] C_INTV  = 3'd6;

  localparam logic [1:0] S_INV   = 2'd0;
  localparam logic [1:0] S_SHR   = 2'd1;
  localparam logic [1:0] S_DIRTY = 2'd3;

  logic              busy;
  logic [2:0]        cmd_q;
  logic [IDX_W-1:0]  addr_q;
  logic              excl_q;
  logic [LINE_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;

  logic [1:0]        st  [LINES];
  logic              l1v [LINES];
  logic [LINE_W-1:0] dat [LINES];
  logic [WORD_W-1:0] irq_q;

  logic [LINE_W-1:0] merged;
  logic [1:0]        cur_st;

  assign req_ready = !busy;
  assign cur_st    = st[addr_q];

  always_comb begin
    merged = dat[addr_q];
    for (int b = 0; b < BE_W; b++)
      if (be_q[b]) merged[b*8 +: 8] = wdata_q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cmd_q <= '0; addr_q <= '0; excl_q <= 1'b0; wdata_q <= '0; be_q <= '0;
      irq_q <= '0;
      done <= 1'b0; rep_valid <= 1'b0; rep_state <= S_INV; rep_l1 <= 1'b0;
      rep_has_data <= 1'b0; rep_data <= '0; bus_err <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        st[i] <= S_INV; l1v[i] <= 1'b0; dat[i] <= '0;
      end
    end else begin
      done <= 1'b0; rep_valid <= 1'b0; rep_state <= S_INV; rep_l1 <= 1'b0;
      rep_has_data <= 1'b0; rep_data <= '0;
      bus_err <= rd_rsp_valid && rd_rsp_err;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1;
          cmd_q <= req_cmd; addr_q <= req_addr; excl_q <= req_excl;
          wdata_q <= req_wdata; be_q <= req_be;
        end
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        case (cmd_q)
          C_READ: begin
            rep_valid <= 1'b1;
            if (addr_q == '0) rep_data <= LINE_W'(irq_q);
          end
          C_WRITE: if (addr_q == '0) irq_q <= wdata_q[WORD_W-1:0];
          C_INVAL: begin
            st[addr_q] <= S_INV; l1v[addr_q] <= 1'b0;
          end
          C_UPD: begin
            dat[addr_q] <= merged; st[addr_q] <= S_DIRTY; l1v[addr_q] <= 1'b1;
          end
          C_SNOOP: begin
            rep_valid <= 1'b1; rep_state <= cur_st; rep_l1 <= l1v[addr_q];
            if (excl_q) begin
              st[addr_q] <= S_INV; l1v[addr_q] <= 1'b0;
            end
          end
          C_INTV: begin
            rep_valid <= 1'b1; rep_state <= cur_st; rep_l1 <= l1v[addr_q];
            if (cur_st == S_DIRTY) begin
              rep_has_data <= 1'b1; rep_data <= dat[addr_q];
            end
            if (excl_q) begin
              st[addr_q] <= S_INV; l1v[addr_q] <= 1'b0;
            end else if (cur_st != S_INV) begin
              st[addr_q] <= S_SHR;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ext_req_unit_chk.sv
module ext_req_unit_chk #(
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_err,
  input logic              done,
  input logic              rep_valid,
  input logic [1:0]        rep_state,
  input logic              rep_has_data,
  input logic [LINE_W-1:0] rep_data,
  input logic              bus_err
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready && !done);

  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 (done && req_ready));

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_reply_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> done);

  a_r10_data_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    rep_has_data |-> (rep_valid && rep_state == 2'd3));

  a_r10_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_valid |-> (rep_data == '0));

  a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && rd_rsp_err) |=> bus_err);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_rsp_valid && rd_rsp_err) |=> !bus_err);
endmodule

bind ext_req_unit ext_req_unit_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .done(done),
  .rep_valid(rep_valid), .rep_state(rep_state), .rep_has_data(rep_has_data),
  .rep_data(rep_data), .bus_err(bus_err)
);

// File: tb/ext_req_unit_bench.sv
module ext_req_unit_bench;
  localparam int LINES = 4, LINE_W = 64, WORD_W = 32;
  localparam int IDX_W = $clog2(LINES), BE_W = LINE_W / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_excl = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [IDX_W-1:0] req_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic [BE_W-1:0] req_be = '0;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic req_ready, done, rep_valid, rep_l1, rep_has_data, bus_err;
  logic [1:0] rep_state;
  logic [LINE_W-1:0] rep_data;

  always #5 clk = ~clk;

  ext_req_unit #(.LINES(LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_ext_req_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_excl(req_excl),
    .req_wdata(req_wdata), .req_be(req_be), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_err(rd_rsp_err), .done(done), .rep_valid(rep_valid),
    .rep_state(rep_state), .rep_l1(rep_l1), .rep_has_data(rep_has_data),
    .rep_data(rep_data), .bus_err(bus_err));

  typedef struct {
    logic              v;
    logic [1:0]        st;
    logic              l1;
    logic              hd;
    logic [LINE_W-1:0] d;
    string             tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [1:0]        m_st  [LINES];
  logic              m_l1  [LINES];
  logic [LINE_W-1:0] m_dat [LINES];
  logic [WORD_W-1:0] m_irq;

  task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] cmd, input int addr, input logic excl,
                       input logic [LINE_W-1:0] wd, input logic [BE_W-1:0] be, input string tag);
    exp_t e;
    e = '{v:1'b0, st:2'd0, l1:1'b0, hd:1'b0, d:'0, tag:tag};
    case (cmd)
      3'd1: begin e.v = 1'b1; if (addr == 0) e.d = LINE_W'(m_irq); end
      3'd2: if (addr == 0) m_irq = wd[WORD_W-1:0];
      3'd3: begin m_st[addr] = 2'd0; m_l1[addr] = 1'b0; end
      3'd4: begin
        for (int b = 0; b < BE_W; b++) if (be[b]) m_dat[addr][b*8 +: 8] = wd[b*8 +: 8];
        m_st[addr] = 2'd3; m_l1[addr] = 1'b1;
      end
      3'd5: begin
        e.v = 1'b1; e.st = m_st[addr]; e.l1 = m_l1[addr];
        if (excl) begin m_st[addr] = 2'd0; m_l1[addr] = 1'b0; end
      end
      3'd6: begin
        e.v = 1'b1; e.st = m_st[addr]; e.l1 = m_l1[addr];
        if (m_st[addr] == 2'd3) begin e.hd = 1'b1; e.d = m_dat[addr]; end
        if (excl) begin m_st[addr] = 2'd0; m_l1[addr] = 1'b0; end
        else if (m_st[addr] != 2'd0) m_st[addr] = 2'd1;
      end
      default: ;
    endcase
    q.push_back(e);
    @(negedge clk);
    chk({tag, " R1 ready before"}, LINE_W'(req_ready), 1);
    req_valid = 1'b1; req_cmd = cmd; req_addr = IDX_W'(addr); req_excl = excl;
    req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 ready low"}, LINE_W'(req_ready), 0);
    chk({tag, " R1 no early done"}, LINE_W'(done), 0);
    @(negedge clk);
    chk({tag, " R1 done"}, LINE_W'(done), 1);
    chk({tag, " R1 ready back"}, LINE_W'(req_ready), 1);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rep_valid && !done) chk("R10 reply without done", 1, 0);
      if (done) begin
        if (q.size() == 0) chk("R1 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " valid"}, LINE_W'(rep_valid), LINE_W'(e.v));
          chk({e.tag, " state"}, LINE_W'(rep_state), LINE_W'(e.st));
          chk({e.tag, " l1"},    LINE_W'(rep_l1), LINE_W'(e.l1));
          chk({e.tag, " hasdata"}, LINE_W'(rep_has_data), LINE_W'(e.hd));
          chk({e.tag, " data"}, rep_data, e.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 2'd0; m_l1[i] = 1'b0; m_dat[i] = '0; end
    m_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", LINE_W'(req_ready), 1);
    chk("R1 reset done", LINE_W'(done), 0);
    chk("R10 reset reply", LINE_W'(rep_valid), 0);
    chk("R9 reset buserr", LINE_W'(bus_err), 0);

    issue(3'd2, 0, 1'b0, 64'h1111_2222_A5A5_0001, '0, "R3 write irq");
    issue(3'd1, 0, 1'b0, '0, '0, "R3 read irq");
    issue(3'd2, 3, 1'b0, 64'h0000_0000_0000_DEAD, '0, "R3 write elsewhere");
    issue(3'd1, 0, 1'b0, '0, '0, "R3 irq kept");
    issue(3'd1, 3, 1'b0, '0, '0, "R3 read other zero");

    issue(3'd5, 2, 1'b0, '0, '0, "R6 snoop invalid");
    issue(3'd4, 2, 1'b0, 64'h0123_4567_89AB_CDEF, 8'hFF, "R5 full update");
    issue(3'd6, 2, 1'b0, '0, '0, "R7 shared intervention dirty");
    issue(3'd5, 2, 1'b0, '0, '0, "R6 snoop shared keeps");
    issue(3'd6, 2, 1'b0, '0, '0, "R7 shared intervention clean");
    issue(3'd4, 2, 1'b0, 64'hFFFF_FFFF_5555_AAAA, 8'h0F, "R5 partial update");
    issue(3'd6, 2, 1'b1, '0, '0, "R7 excl intervention");
    issue(3'd5, 2, 1'b0, '0, '0, "R7 line gone");

    issue(3'd4, 3, 1'b0, 64'hCAFE_F00D_0000_0003, 8'hC3, "R5 update top line");
    issue(3'd5, 3, 1'b1, '0, '0, "R6 excl snoop");
    issue(3'd5, 3, 1'b0, '0, '0, "R6 after excl snoop");

    issue(3'd4, 0, 1'b0, 64'h0000_0000_0000_00FF, 8'h01, "R4 prep");
    issue(3'd3, 0, 1'b0, '0, '0, "R4 invalidate");
    issue(3'd6, 0, 1'b0, '0, '0, "R4 invalidated seen");

    issue(3'd4, 1, 1'b0, 64'h7777_0000_0000_7777, 8'hFF, "R8 prep");
    issue(3'd0, 1, 1'b1, 64'hFFFF, 8'hFF, "R8 null");
    issue(3'd7, 1, 1'b1, 64'hFFFF, 8'hFF, "R2 code7 null");
    issue(3'd6, 1, 1'b0, '0, '0, "R8 line untouched");

    @(negedge clk);
    rd_rsp_valid = 1'b1; rd_rsp_err = 1'b1;
    @(negedge clk);
    chk("R9 bus error raised", LINE_W'(bus_err), 1);
    rd_rsp_err = 1'b0;
    @(negedge clk);
    chk("R9 clean beat", LINE_W'(bus_err), 0);
    rd_rsp_valid = 1'b0; rd_rsp_err = 1'b1;
    @(negedge clk);
    chk("R9 err without valid", LINE_W'(bus_err), 0);
    rd_rsp_err = 1'b0;
    @(negedge clk);
    chk("R1 queue drained", LINE_W'(q.size()), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule